// File: doc/BRIEF.md
# Beacon Timer Scheduler

This block keeps a 64-bit time-synchronisation counter (TSF) that advances once per microsecond. Four 16-bit-range beacon timers are scheduled against it: the next beacon target time, the DMA beacon alert, the software beacon alert and the end of the ATIM window. Each timer watches a slice of the TSF that gives either whole time units (TU, 1024 µs) or eighths of a TU. When that slice reaches the timer's stored value, the timer emits a one-clock event pulse and moves forward by one beacon interval.

Software programs the block through a single write port. One address each holds the low TSF word, the high TSF word, the four timers and a control word. The control word carries the beacon interval, the timer enable and a toggling TSF-reset bit. A separate load port lets the receive path jump the TSF to a value taken from a received beacon.

Each timer advances on its own, so a jump can carry the TSF past one timer and not past another. The skewed timer then fires again only after its 16-bit TU count wraps. A wrap-aware window checker therefore reports whether the ATIM end and the DMA alert still sit at their intended distances from the target time.

Top module: `bcn_sched`

## Requirements
- R1: After reset `tsf_o` is 0, all event outputs are 0 and `win_ok_o` is 0, since every timer and the interval are zero. From then on the TSF grows by one every `US_DIV` clocks.
- R2: A write to address 0 replaces TSF bits [31:0], and a write to address 1 replaces bits [63:32]. The other half is kept, and the new value shows on `tsf_o` in the clock after the write. A jump load replaces all 64 bits and overrides a word write in the same clock.
- R3: Address 6 is the control word. Each write to it with bit 25 set toggles an internal reset request. A request going from 0 to 1 clears the TSF at the following clock edge. A write that returns the request to 0 does not touch the TSF. The clear has priority over a jump load in the same clock.
- R4: The target timer (address 2) and the ATIM timer (address 5) hold TU values in data bits [15:0] and are compared with TSF bits [25:10]. When that count becomes equal to the timer, the matching event output is high for exactly one clock. That clock is the one after the first microsecond of the TU. The timer then advances by the interval held in control bits [15:0].
- R5: The DMA alert timer (address 3) and the software alert timer (address 4) hold 1/8-TU values in data bits [18:0] and are compared with TSF bits [25:7]. They advance by eight times the interval.
- R6: A timer compares only in a clock where its own time slice changes. A jump that carries the slice past a timer's value leaves that timer unfired, and its event stays low.
- R7: Control bit 24 enables the timers. While it is 0, no event fires and no timer advances.
- R8: For a window w, interval i and timers a, b, the window test passes if any one of these holds:
  - (a | 0x10000) − b = i − w;
  - b − a = w;
  - (b | 0x10000) − a = w;
  - a − b = i − w.
- R9: `win_ok_o` is high exactly when two window tests pass. The first has a = target, b = ATIM and w = 1. The second has a = DMA alert ≫ 3, b = target and w = `DMA_RESP` (default 2).
- R10: A timer write loads the written value directly, and it overrides an advance in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0..6) |
| wr_data_i | input | 32 | Register write data |
| jump_en_i | input | 1 | TSF jump load strobe |
| jump_tsf_i | input | 64 | TSF value for a jump load |
| tsf_o | output | 64 | Current TSF in microseconds |
| tbtt_ev_o | output | 1 | Target beacon time event |
| dma_ev_o | output | 1 | DMA beacon alert event |
| swba_ev_o | output | 1 | Software beacon alert event |
| atim_ev_o | output | 1 | ATIM window end event |
| win_ok_o | output | 1 | Timer window health flag |

## Verification
The bench walks a table of timer triples that cover each of the four window arms. These include the target at 0xFFFF with the ATIM at 0, the target already advanced past the ATIM, and the DMA alert wrapped behind the target. A checker that ignored the wrap arms would drop the flag on healthy timers near rollover, and a zero-width ATIM window must read as unhealthy. Jumps land the TSF two microseconds before a timer so the event cycle is checked exactly. Other jumps skip past a timer to show that it stays silent, and revisit an old TU after an advance to show that nothing fires there. A design that compared on every clock would stretch pulses or refire, and one that ignored the enable would advance timers while disabled. Writing the reset bit twice checks that only the first write clears the TSF, and a jump issued during the clear checks that the clear wins.

// File: rtl/bcn_pkg.sv
package bcn_pkg;
  typedef enum logic [2:0] {
    REG_TSF_LO = 3'd0,
    REG_TSF_HI = 3'd1,
    REG_TBTT   = 3'd2,
    REG_DMA    = 3'd3,
    REG_SWBA   = 3'd4,
    REG_ATIM   = 3'd5,
    REG_CTRL   = 3'd6
  } reg_addr_e;

  localparam int TSF_W        = 64;
  localparam int CTRL_EN_BIT  = 24;
  localparam int CTRL_RST_BIT = 25;
endpackage

// File: rtl/bcn_tsf_ctr.sv
module bcn_tsf_ctr #(
  parameter int US_DIV = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        ld_i,
  input  logic [63:0] ld_val_i,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wr_data_i,
  output logic [63:0] tsf_o
);
  logic [63:0] tsf_q;
  logic        tick;

  generate
    if (US_DIV <= 1) begin : g_no_div
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(US_DIV);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          div_q <= '0;
        else if (div_q == DW'(US_DIV - 1))    div_q <= '0;
        else                                  div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DW'(US_DIV - 1));
    end
  endgenerate

  // priority: clear > jump load > word write > count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tsf_q <= '0;
    else if (clr_i)   tsf_q <= '0;
    else if (ld_i)    tsf_q <= ld_val_i;
    else if (wr_lo_i) tsf_q[31:0]  <= wr_data_i;
    else if (wr_hi_i) tsf_q[63:32] <= wr_data_i;
    else if (tick)    tsf_q <= tsf_q + 64'd1;
  end

  assign tsf_o = tsf_q;

  AST_TSF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni) clr_i |=> (tsf_q == '0)); // R3
  AST_TSF_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni) (ld_i && !clr_i) |=> (tsf_q == $past(ld_val_i))); // R2
  AST_TSF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni) (tick && !clr_i && !ld_i && !wr_lo_i && !wr_hi_i) |=> (tsf_q == $past(tsf_q) + 64'd1)); // R1
endmodule

// File: rtl/bcn_ctrl.sv
module bcn_ctrl #(
  parameter int TU_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [TU_W-1:0] ivl_i,
  input  logic            en_i,
  input  logic            rst_bit_i,
  output logic [TU_W-1:0] ivl_o,
  output logic            en_o,
  output logic            clr_o
);
  logic [TU_W-1:0] ivl_q;
  logic            en_q, req_q, req_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ivl_q   <= '0;
      en_q    <= 1'b0;
      req_q   <= 1'b0;
      req_d_q <= 1'b0;
    end else begin
      req_d_q <= req_q;
      if (wr_i) begin
        ivl_q <= ivl_i;
        en_q  <= en_i;
        if (rst_bit_i) req_q <= ~req_q;
      end
    end
  end

  // clear fires once on the rising edge of the toggled request
  assign clr_o = req_q & ~req_d_q;
  assign ivl_o = ivl_q;
  assign en_o  = en_q;

  AST_RST_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) (wr_i && rst_bit_i) |=> (req_q != $past(req_q))); // R3
  AST_CLR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) clr_o |=> !clr_o); // R3
endmodule

// File: rtl/bcn_timer.sv
module bcn_timer #(
  parameter int TU_W = 16,
  parameter int SH   = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [TU_W+SH-1:0] wr_val_i,
  input  logic [TU_W+SH-1:0] base_i,
  input  logic               en_i,
  input  logic [TU_W-1:0]    ivl_i,
  output logic [TU_W+SH-1:0] tmr_o,
  output logic               ev_o
);
  localparam int W = TU_W + SH;

  logic [W-1:0] tmr_q, base_q, step;
  logic         ev_q, chg, hit;

  assign step = W'(ivl_i) << SH;
  assign chg  = (base_i != base_q);
  assign hit  = en_i && chg && (base_i == tmr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      base_q <= '0;
      ev_q   <= 1'b0;
    end else begin
      base_q <= base_i;
      ev_q   <= hit;
      if (wr_i)     tmr_q <= wr_val_i;
      else if (hit) tmr_q <= tmr_q + step;
    end
  end

  assign tmr_o = tmr_q;
  assign ev_o  = ev_q;

  AST_EV_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni) ev_o |-> ($past(base_i) == $past(tmr_q) && $past(en_i))); // R4
  AST_NO_REFIRE: assert property (@(posedge clk_i) disable iff (!rst_ni) $stable(base_i) |=> !ev_o); // R6
  AST_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni) (ev_o && !$past(wr_i)) |-> (tmr_q == $past(tmr_q) + $past(step))); // R5
  AST_WRITE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_i |=> (tmr_q == $past(wr_val_i))); // R10
endmodule

// File: rtl/bcn_win_chk.sv
module bcn_win_chk #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] win_i,
  input  logic [W-1:0] ivl_i,
  output logic         ok_o
);
  localparam int SW = W + 3;
  localparam logic signed [SW-1:0] WRAP = SW'(1) << W;

  logic signed [SW-1:0] a, b, w, iv;

  assign a  = $signed({3'b000, a_i});
  assign b  = $signed({3'b000, b_i});
  assign w  = $signed({3'b000, win_i});
  assign iv = $signed({3'b000, ivl_i});

  // plain, a advanced, a advanced and wrapped, b wrapped
  assign ok_o = ((b - a) == w) ||
                ((a - b) == (iv - w)) ||
                ((a + WRAP - b) == (iv - w)) ||
                ((b + WRAP - a) == w);
endmodule

// File: rtl/bcn_sched.sv
module bcn_sched
  import bcn_pkg::*;
#(
  parameter int US_DIV   = 1,
  parameter int TU_W     = 16,
  parameter int SUB_SH   = 3,
  parameter int TU_LSB   = 10,
  parameter int DMA_RESP = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic        jump_en_i,
  input  logic [63:0] jump_tsf_i,
  output logic [63:0] tsf_o,
  output logic        tbtt_ev_o,
  output logic        dma_ev_o,
  output logic        swba_ev_o,
  output logic        atim_ev_o,
  output logic        win_ok_o
);
  localparam int SUB_W   = TU_W + SUB_SH;
  localparam int SUB_LSB = TU_LSB - SUB_SH;

  logic [63:0]      tsf;
  logic [TU_W-1:0]  tu_base, ivl, tbtt_tmr, atim_tmr;
  logic [SUB_W-1:0] sub_base, dma_tmr, swba_tmr;
  logic             en, clr, ok_atim, ok_dma;
  logic             wr_lo, wr_hi, wr_tbtt, wr_dma, wr_swba, wr_atim, wr_ctrl;

  assign wr_lo   = wr_en_i && (wr_addr_i == REG_TSF_LO);
  assign wr_hi   = wr_en_i && (wr_addr_i == REG_TSF_HI);
  assign wr_tbtt = wr_en_i && (wr_addr_i == REG_TBTT);
  assign wr_dma  = wr_en_i && (wr_addr_i == REG_DMA);
  assign wr_swba = wr_en_i && (wr_addr_i == REG_SWBA);
  assign wr_atim = wr_en_i && (wr_addr_i == REG_ATIM);
  assign wr_ctrl = wr_en_i && (wr_addr_i == REG_CTRL);

  bcn_ctrl #(.TU_W(TU_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_ctrl),
    .ivl_i     (wr_data_i[TU_W-1:0]),
    .en_i      (wr_data_i[CTRL_EN_BIT]),
    .rst_bit_i (wr_data_i[CTRL_RST_BIT]),
    .ivl_o     (ivl),
    .en_o      (en),
    .clr_o     (clr)
  );

  bcn_tsf_ctr #(.US_DIV(US_DIV)) u_tsf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .ld_i      (jump_en_i),
    .ld_val_i  (jump_tsf_i),
    .wr_lo_i   (wr_lo),
    .wr_hi_i   (wr_hi),
    .wr_data_i (wr_data_i),
    .tsf_o     (tsf)
  );

  assign tu_base  = tsf[TU_LSB +: TU_W];
  assign sub_base = tsf[SUB_LSB +: SUB_W];

  bcn_timer #(.TU_W(TU_W), .SH(0)) u_tbtt (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_i (wr_tbtt),
    .wr_val_i (wr_data_i[TU_W-1:0]), .base_i (tu_base), .en_i (en),
    .ivl_i (ivl), .tmr_o (tbtt_tmr), .ev_o (tbtt_ev_o)
  );

  bcn_timer #(.TU_W(TU_W), .SH(SUB_SH)) u_dma (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_i (wr_dma),
    .wr_val_i (wr_data_i[SUB_W-1:0]), .base_i (sub_base), .en_i (en),
    .ivl_i (ivl), .tmr_o (dma_tmr), .ev_o (dma_ev_o)
  );

  bcn_timer #(.TU_W(TU_W), .SH(SUB_SH)) u_swba (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_i (wr_swba),
    .wr_val_i (wr_data_i[SUB_W-1:0]), .base_i (sub_base), .en_i (en),
    .ivl_i (ivl), .tmr_o (swba_tmr), .ev_o (swba_ev_o)
  );

  bcn_timer #(.TU_W(TU_W), .SH(0)) u_atim (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_i (wr_atim),
    .wr_val_i (wr_data_i[TU_W-1:0]), .base_i (tu_base), .en_i (en),
    .ivl_i (ivl), .tmr_o (atim_tmr), .ev_o (atim_ev_o)
  );

  bcn_win_chk #(.W(TU_W)) u_chk_atim (
    .a_i (tbtt_tmr), .b_i (atim_tmr), .win_i (TU_W'(1)), .ivl_i (ivl), .ok_o (ok_atim)
  );

  bcn_win_chk #(.W(TU_W)) u_chk_dma (
    .a_i (dma_tmr[SUB_W-1:SUB_SH]), .b_i (tbtt_tmr), .win_i (TU_W'(DMA_RESP)),
    .ivl_i (ivl), .ok_o (ok_dma)
  );

  assign win_ok_o = ok_atim && ok_dma;
  assign tsf_o    = tsf;

  AST_SWBA_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_swba |=> (swba_tmr == $past(wr_data_i[SUB_W-1:0]))); // R10
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) (!en && !wr_tbtt) |=> ($stable(tbtt_tmr) && !tbtt_ev_o)); // R7
  AST_CLR_BEATS_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni) (clr && jump_en_i) |=> (tsf_o == '0)); // R3
endmodule

// File: tb/bcn_sched_tb.sv
module bcn_sched_tb;
  localparam logic [2:0] A_LO = 3'd0, A_HI = 3'd1, A_TBTT = 3'd2, A_DMA = 3'd3,
                         A_SWBA = 3'd4, A_ATIM = 3'd5, A_CTRL = 3'd6;
  localparam logic [31:0] EN  = 32'h0100_0000;
  localparam logic [31:0] RST = 32'h0200_0000;

  // {target[51:36], atim[35:20], dma[19:1], ok[0]}, interval 100
  localparam logic [51:0] VEC [0:7] = '{
    {16'd100,    16'd101,    19'd784,     1'b1},
    {16'd100,    16'd105,    19'd784,     1'b0},
    {16'd100,    16'd101,    19'd776,     1'b0},
    {16'hFFFF,   16'h0000,   19'h7FFE8,   1'b1},
    {16'd200,    16'd101,    19'd1584,    1'b1},
    {16'h0010,   16'hFFAD,   19'd112,     1'b1},
    {16'd1,      16'd2,      19'h7FFF8,   1'b1},
    {16'd50,     16'd50,     19'd384,     1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        jump_en_i = 1'b0;
  logic [63:0] jump_tsf_i = '0;
  logic [63:0] tsf_o;
  logic        tbtt_ev_o, dma_ev_o, swba_ev_o, atim_ev_o, win_ok_o;

  int checks = 0, fails = 0;
  int n_tbtt = 0, n_dma = 0, n_swba = 0, n_atim = 0;

  always #5 clk_i = ~clk_i;

  bcn_sched u_dut (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .jump_en_i, .jump_tsf_i,
    .tsf_o, .tbtt_ev_o, .dma_ev_o, .swba_ev_o, .atim_ev_o, .win_ok_o
  );

  always @(posedge clk_i) begin
    if (tbtt_ev_o) n_tbtt <= n_tbtt + 1;
    if (dma_ev_o)  n_dma  <= n_dma + 1;
    if (swba_ev_o) n_swba <= n_swba + 1;
    if (atim_ev_o) n_atim <= n_atim + 1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic jump(input logic [63:0] v);
    @(negedge clk_i);
    jump_en_i = 1'b1; jump_tsf_i = v;
    @(negedge clk_i);
    jump_en_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] t0;
    int s_tbtt, s_dma, s_swba, s_atim;

    repeat (3) @(negedge clk_i);
    chk("R1 reset tsf", tsf_o, 64'd0);
    chk("R1 reset events", {60'd0, tbtt_ev_o, dma_ev_o, swba_ev_o, atim_ev_o}, 64'd0);
    chk("R1 reset health", {63'd0, win_ok_o}, 64'd0);
    rst_ni = 1'b1;

    // R1 counting
    @(negedge clk_i);
    t0 = tsf_o;
    repeat (10) @(negedge clk_i);
    chk("R1 count", tsf_o, t0 + 64'd10);

    // R2 word writes and jump priority
    wr(A_LO, 32'h1234_5678);
    chk("R2 low word", {32'd0, tsf_o[31:0]}, 64'h1234_5678);
    chk("R2 high kept", {32'd0, tsf_o[63:32]}, 64'd0);
    wr(A_HI, 32'hABCD_0001);
    chk("R2 high word", {32'd0, tsf_o[63:32]}, 64'hABCD_0001);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = A_LO; wr_data_i = 32'h0;
    jump_en_i = 1'b1; jump_tsf_i = 64'h0000_0002_0000_0100;
    @(negedge clk_i);
    wr_en_i = 1'b0; jump_en_i = 1'b0;
    chk("R2 jump beats write", tsf_o, 64'h0000_0002_0000_0100);

    // R3 reset toggle
    wr(A_CTRL, RST | 32'd100);
    @(negedge clk_i);
    chk("R3 first write clears", tsf_o, 64'd0);
    wr(A_CTRL, RST | 32'd100);
    t0 = tsf_o;
    @(negedge clk_i);
    chk("R3 second write no clear", tsf_o, t0 + 64'd1);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = A_CTRL; wr_data_i = RST | 32'd100;
    @(negedge clk_i);
    wr_en_i = 1'b0; jump_en_i = 1'b1; jump_tsf_i = 64'hDEAD;
    @(negedge clk_i);
    jump_en_i = 1'b0;
    chk("R3 clear beats jump", tsf_o, 64'd0);

    // R8 / R9 window table
    wr(A_CTRL, 32'd100);
    for (int i = 0; i < 8; i++) begin
      wr(A_TBTT, {16'd0, VEC[i][51:36]});
      wr(A_ATIM, {16'd0, VEC[i][35:20]});
      wr(A_DMA,  {13'd0, VEC[i][19:1]});
      chk($sformatf("R8 R9 vector %0d", i), {63'd0, win_ok_o}, {63'd0, VEC[i][0]});
    end

    // R4 exact event timing, R10 timer load
    wr(A_TBTT, 32'd5);
    wr(A_ATIM, 32'd6);
    wr(A_DMA,  32'd24);
    wr(A_SWBA, 32'd16);
    wr(A_CTRL, EN | 32'd100);
    s_tbtt = n_tbtt; s_dma = n_dma; s_swba = n_swba; s_atim = n_atim;
    jump(64'd5118);
    repeat (2) @(negedge clk_i);
    chk("R4 no early event", {63'd0, tbtt_ev_o}, 64'd0);
    @(negedge clk_i);
    chk("R10 loaded target fires", {63'd0, tbtt_ev_o}, 64'd1);
    @(negedge clk_i);
    chk("R4 one clock pulse", {63'd0, tbtt_ev_o}, 64'd0);
    repeat (1100) @(negedge clk_i);
    chk("R4 atim fires once", 64'(n_atim - s_atim), 64'd1);
    chk("R4 target single pulse", 64'(n_tbtt - s_tbtt), 64'd1);
    chk("R6 dma skipped by jump", 64'(n_dma - s_dma), 64'd0);
    chk("R6 swba skipped by jump", 64'(n_swba - s_swba), 64'd0);

    // R4 advance by interval
    s_tbtt = n_tbtt;
    jump(64'd107518);
    repeat (5) @(negedge clk_i);
    chk("R4 advanced target fires", 64'(n_tbtt - s_tbtt), 64'd1);
    s_tbtt = n_tbtt;
    jump(64'd5118);
    repeat (5) @(negedge clk_i);
    chk("R4 old TU silent", 64'(n_tbtt - s_tbtt), 64'd0);

    // R5 eighth-TU timers
    wr(A_DMA, 32'd400);
    s_dma = n_dma;
    jump(64'd51198);
    repeat (5) @(negedge clk_i);
    chk("R5 dma fires", 64'(n_dma - s_dma), 64'd1);
    s_dma = n_dma;
    jump(64'd153598);
    repeat (5) @(negedge clk_i);
    chk("R5 dma advanced by 8x interval", 64'(n_dma - s_dma), 64'd1);
    s_dma = n_dma;
    jump(64'd51198);
    repeat (5) @(negedge clk_i);
    chk("R5 dma old slot silent", 64'(n_dma - s_dma), 64'd0);
    wr(A_SWBA, 32'd1000);
    s_swba = n_swba;
    jump(64'd127998);
    repeat (5) @(negedge clk_i);
    chk("R5 swba fires", 64'(n_swba - s_swba), 64'd1);

    // R7 enable gating
    wr(A_CTRL, 32'd100);
    wr(A_TBTT, 32'd300);
    s_tbtt = n_tbtt;
    jump(64'd307198);
    repeat (5) @(negedge clk_i);
    chk("R7 disabled no event", 64'(n_tbtt - s_tbtt), 64'd0);
    wr(A_CTRL, EN | 32'd100);
    jump(64'd307198);
    repeat (5) @(negedge clk_i);
    chk("R7 timer not advanced while disabled", 64'(n_tbtt - s_tbtt), 64'd1);

    finish_run();
  end
endmodule